// File: doc/BRIEF.md
# Scratchpad / FIFO Fill-Level Readback Port

This block is one byte-wide slot of a UART-style register file. It lives at a single bus address and plays one of two roles. With the feature-control swap bit low, the slot is an ordinary read/write scratch byte. With the swap bit high, a write to the slot lands in a small write-only mode register, and a read returns a FIFO occupancy count.

The mode register chooses the count that a read returns. It can return the receive level, the transmit level, or both in turn. In the alternating mode, each completed read at the slot flips an internal pointer. The first read after any mode write always returns the receive level.

Read data is registered. It appears on `rd_data` in the cycle after the read strobe and is zero in every other cycle, so the slice can be OR-combined with its neighbours. Incoming level counts are clipped to the FIFO depth before they are returned.

Top module: `scratch_level_port`

## Requirements
- R1: After reset, the scratch byte is 0, the mode field is 00, the alternation pointer selects receive next, and `rd_data` is 0.
- R2: With `swap_en`=0, a write at `PORT_ADDR` stores `wr_data` in the scratch byte. A later read there returns it on `rd_data` one cycle after the read strobe.
- R3: With `swap_en`=0, the stored mode field has no effect on reads, and writes leave the mode field unchanged.
- R4: With `swap_en`=1, a write at `PORT_ADDR` loads `wr_data[1:0]` into the mode field and leaves the scratch byte unchanged.
- R5: With `swap_en`=1 and mode bit 0 clear (mode 00 or 10), a read returns the receive level.
- R6: With `swap_en`=1 and mode 01 (bit 0 set, bit 1 clear), a read returns the transmit level.
- R7: With `swap_en`=1 and mode 11, successive reads return receive, transmit, receive, transmit, and so on.
- R8: Every mode write (`swap_en`=1, write at `PORT_ADDR`) sets the alternation pointer back to receive-next, even when the mode value does not change.
- R9: Reads and writes at any other address change neither the pointer nor the stored state. `rd_data` is 0 in the cycle after such a read.
- R10: A returned level count is the input count clipped to `FIFO_DEPTH` (128 by default). Inputs above it read as 128.
- R11: `rd_data` is 0 in any cycle whose previous cycle had no read strobe at `PORT_ADDR`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| wr_data | input | 8 | Write data |
| swap_en | input | 1 | Swap bit from the feature-control register |
| rx_level | input | LVL_W | Receive FIFO occupancy |
| tx_level | input | LVL_W | Transmit FIFO occupancy |
| rd_data | output | 8 | Registered read data, zero when idle |

## Verification
A wrong alternation pointer shows up on the very next read at the slot. That read returns the transmit level where the receive level was due, or the reverse, one cycle after the strobe. A corrupted mode field or scratch byte stays hidden until the next read at the slot in the matching swap state. The bench therefore follows each state-changing access with reads that expose it. Using distinct receive and transmit levels makes any mix-up visible as a wrong byte.

// File: rtl/scratch_level_pkg.sv
package scratch_level_pkg;
    localparam int DATA_W = 8;
    localparam int MODE_W = 2;

    // Mode field values (wr_data[1:0] while swap is on)
    localparam logic [MODE_W-1:0] MODE_RX     = 2'b00;
    localparam logic [MODE_W-1:0] MODE_TX     = 2'b01;
    localparam logic [MODE_W-1:0] MODE_ALT    = 2'b11;

    typedef struct packed {
        logic [DATA_W-1:0] scratch;
        logic [MODE_W-1:0] mode;
        logic              tx_next;
        logic [DATA_W-1:0] rdata;
    } port_state_t;
endpackage

// File: rtl/level_clip.sv
module level_clip #(
    parameter int IN_W  = 8,
    parameter int OUT_W = 8,
    parameter int LIMIT = 128
) (
    input  logic [IN_W-1:0]  count_in,
    output logic [OUT_W-1:0] count_out
);
    localparam logic [IN_W-1:0]  LIMIT_IN  = IN_W'(LIMIT);
    localparam logic [OUT_W-1:0] LIMIT_OUT = OUT_W'(LIMIT);

    always_comb begin
        if (count_in > LIMIT_IN) count_out = LIMIT_OUT;
        else                     count_out = OUT_W'(count_in);
    end
endmodule

// File: rtl/level_port_mux.sv
module level_port_mux
    import scratch_level_pkg::*;
(
    input  logic              swap_on,
    input  logic [MODE_W-1:0] mode,
    input  logic              tx_next,
    input  logic [DATA_W-1:0] scratch,
    input  logic [DATA_W-1:0] rx_clip,
    input  logic [DATA_W-1:0] tx_clip,
    output logic [DATA_W-1:0] value
);
    always_comb begin
        if (!swap_on)                     value = scratch;
        else if (!mode[0])                value = rx_clip;
        else if (!mode[1])                value = tx_clip;
        else                              value = tx_next ? tx_clip : rx_clip;
    end
endmodule

// File: rtl/scratch_level_port.sv
module scratch_level_port
    import scratch_level_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int PORT_ADDR  = 7,
    parameter int LVL_W      = 8,
    parameter int FIFO_DEPTH = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [7:0]        wr_data,
    input  logic              swap_en,
    input  logic [LVL_W-1:0]  rx_level,
    input  logic [LVL_W-1:0]  tx_level,
    output logic [7:0]        rd_data
);
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(PORT_ADDR);
    localparam int                N_CH    = 2;

    port_state_t state_d, state_q;

    logic [LVL_W-1:0]  lvl_raw  [N_CH];
    logic [DATA_W-1:0] lvl_clip [N_CH];
    logic [DATA_W-1:0] mux_value;
    logic              hit, rd_hit, wr_hit;

    assign lvl_raw[0] = rx_level;
    assign lvl_raw[1] = tx_level;

    for (genvar ch = 0; ch < N_CH; ch++) begin : g_clip
        level_clip #(
            .IN_W (LVL_W),
            .OUT_W(DATA_W),
            .LIMIT(FIFO_DEPTH)
        ) i_clip (
            .count_in (lvl_raw[ch]),
            .count_out(lvl_clip[ch])
        );
    end

    level_port_mux i_mux (
        .swap_on(swap_en),
        .mode   (state_q.mode),
        .tx_next(state_q.tx_next),
        .scratch(state_q.scratch),
        .rx_clip(lvl_clip[0]),
        .tx_clip(lvl_clip[1]),
        .value  (mux_value)
    );

    assign hit    = (bus_addr == MY_ADDR);
    assign rd_hit = bus_rd && hit;
    assign wr_hit = bus_wr && hit;

    always_comb begin
        state_d = state_q;
        if (wr_hit) begin
            if (swap_en) begin
                state_d.mode    = wr_data[MODE_W-1:0];
                state_d.tx_next = 1'b0;
            end else begin
                state_d.scratch = wr_data;
            end
        end else if (rd_hit && swap_en && state_q.mode == MODE_ALT) begin
            state_d.tx_next = !state_q.tx_next;
        end
        state_d.rdata = rd_hit ? mux_value : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign rd_data = state_q.rdata;

    // Idle cycles return zero
    assert_idle_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |=> rd_data == '0);

    // Receive-only modes return the clipped receive level
    assert_rx_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && swap_en && !state_q.mode[0]) |=> rd_data == $past(lvl_clip[0]));

    // Transmit-only mode returns the clipped transmit level
    assert_tx_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && swap_en && state_q.mode == MODE_TX) |=> rd_data == $past(lvl_clip[1]));

    // Mode writes leave the scratch byte alone
    assert_scratch_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && swap_en) |=> $stable(state_q.scratch));

    // Each alternating-mode read flips the pointer
    assert_alt_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !bus_wr && swap_en && state_q.mode == MODE_ALT)
            |=> state_q.tx_next != $past(state_q.tx_next));

    // Any mode write restarts the sequence on receive
    assert_alt_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && swap_en) |=> !state_q.tx_next);

    // Off-address traffic changes no stored state
    assert_other_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |=> ($stable(state_q.scratch) && $stable(state_q.mode) && $stable(state_q.tx_next)));

    // Returned levels never exceed the depth
    assert_clip_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && swap_en) |=> rd_data <= DATA_W'(FIFO_DEPTH));
endmodule

// File: tb/test_scratch_level_port.sv
`timescale 1ns/1ps
module test_scratch_level_port;
    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] PORT = 3'd7;
    localparam logic [ADDR_W-1:0] OTHER = 3'd2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic             bus_rd = 1'b0;
    logic             bus_wr = 1'b0;
    logic [7:0]       wr_data = '0;
    logic             swap_en = 1'b0;
    logic [7:0]       rx_level = '0;
    logic [7:0]       tx_level = '0;
    logic [7:0]       rd_data;

    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    scratch_level_port #(.ADDR_W(ADDR_W), .PORT_ADDR(7), .LVL_W(8), .FIFO_DEPTH(128))
    i_scratch_level_port (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .wr_data(wr_data), .swap_en(swap_en), .rx_level(rx_level), .tx_level(tx_level),
        .rd_data(rd_data)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; wr_data = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data;
    endtask

    task automatic t_reset();
        logic [7:0] v;
        chk("R1 rd_data after reset", rd_data, 8'd0);
        bus_read(PORT, v);
        chk("R1 scratch after reset", v, 8'd0);
        rx_level = 8'd21; tx_level = 8'd33; swap_en = 1'b1;
        bus_read(PORT, v);
        chk("R1 mode 00 after reset", v, 8'd21);
        swap_en = 1'b0;
    endtask

    task automatic t_scratch();
        logic [7:0] v;
        bus_write(PORT, 8'hA5);
        bus_read(PORT, v);
        chk("R2 scratch A5", v, 8'hA5);
        bus_write(PORT, 8'h3C);
        bus_read(PORT, v);
        chk("R2 scratch 3C", v, 8'h3C);
    endtask

    task automatic t_swap_write();
        logic [7:0] v;
        swap_en = 1'b1;
        bus_write(PORT, 8'hF1);      // mode 01, upper bits must not reach scratch
        swap_en = 1'b0;
        bus_read(PORT, v);
        chk("R4 scratch unchanged by mode write", v, 8'h3C);
    endtask

    task automatic t_mode_ignored();
        logic [7:0] v;
        // mode is 01 now; swap off must read scratch
        bus_read(PORT, v);
        chk("R3 mode ignored on read", v, 8'h3C);
        bus_write(PORT, 8'h00);       // swap off: must not touch mode
        swap_en = 1'b1;
        bus_read(PORT, v);
        chk("R3 mode kept across scratch write", v, tx_level);
        swap_en = 1'b0;
        bus_read(PORT, v);
        chk("R3 scratch written", v, 8'h00);
    endtask

    task automatic t_single_modes();
        logic [7:0] v;
        swap_en = 1'b1; rx_level = 8'd5; tx_level = 8'd9;
        bus_write(PORT, 8'h00);
        bus_read(PORT, v); chk("R5 mode 00", v, 8'd5);
        bus_read(PORT, v); chk("R5 mode 00 repeat", v, 8'd5);
        bus_write(PORT, 8'h02);
        bus_read(PORT, v); chk("R5 mode 10", v, 8'd5);
        bus_write(PORT, 8'h01);
        bus_read(PORT, v); chk("R6 mode 01", v, 8'd9);
        bus_read(PORT, v); chk("R6 mode 01 repeat", v, 8'd9);
    endtask

    task automatic t_alt();
        logic [7:0] v;
        swap_en = 1'b1; rx_level = 8'd5; tx_level = 8'd9;
        bus_write(PORT, 8'h03);
        bus_read(PORT, v); chk("R7 alt first rx", v, 8'd5);
        bus_read(PORT, v); chk("R7 alt second tx", v, 8'd9);
        bus_read(PORT, v); chk("R7 alt third rx", v, 8'd5);
        bus_read(PORT, v); chk("R7 alt fourth tx", v, 8'd9);
        bus_read(PORT, v); chk("R7 alt fifth rx", v, 8'd5);
        // pointer now at tx; rewrite same mode
        bus_write(PORT, 8'h03);
        bus_read(PORT, v); chk("R8 restart to rx", v, 8'd5);
        bus_write(PORT, 8'h03);
        bus_read(PORT, v); chk("R8 restart again rx", v, 8'd5);
    endtask

    task automatic t_other_addr();
        logic [7:0] v;
        swap_en = 1'b1; rx_level = 8'd5; tx_level = 8'd9;
        bus_write(PORT, 8'h03);
        bus_read(PORT, v);  chk("R9 setup rx", v, 8'd5);
        bus_read(OTHER, v); chk("R9 other read gives zero", v, 8'd0);
        bus_read(OTHER, v); chk("R9 other read gives zero again", v, 8'd0);
        bus_write(OTHER, 8'h00);
        bus_read(PORT, v);  chk("R9 pointer kept at tx", v, 8'd9);
        swap_en = 1'b0;
        bus_write(OTHER, 8'hEE);
        bus_read(PORT, v);  chk("R9 scratch untouched", v, 8'h00);
    endtask

    task automatic t_clip();
        logic [7:0] v;
        swap_en = 1'b1;
        bus_write(PORT, 8'h00);
        rx_level = 8'd200; bus_read(PORT, v); chk("R10 rx 200 clipped", v, 8'd128);
        rx_level = 8'd128; bus_read(PORT, v); chk("R10 rx 128 kept", v, 8'd128);
        rx_level = 8'd127; bus_read(PORT, v); chk("R10 rx 127 kept", v, 8'd127);
        bus_write(PORT, 8'h01);
        tx_level = 8'd255; bus_read(PORT, v); chk("R10 tx 255 clipped", v, 8'd128);
        tx_level = 8'd129; bus_read(PORT, v); chk("R10 tx 129 clipped", v, 8'd128);
    endtask

    task automatic t_idle();
        @(negedge clk);
        bus_addr = PORT; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R11 read cycle nonzero", rd_data, 8'd128);
        @(negedge clk);
        chk("R11 idle after read", rd_data, 8'd0);
        bus_write(PORT, 8'h01);
        chk("R11 idle after write", rd_data, 8'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_scratch();
        t_swap_write();
        t_mode_ignored();
        t_single_modes();
        t_alt();
        t_other_addr();
        t_clip();
        t_idle();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #100000;
        total++; bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule